// File: doc/BRIEF.md
# Calibration Trigger and Sequencing Controller

This controller decides when a converter's self-calibration is allowed to run and reports its progress. After reset it runs one automatic calibration once a power-on delay has passed. A delay-select input picks the length of that delay. After that, calibration starts only on command. The request input is level sensitive and sampled on the sampling clock. It must first be seen low for a qualification window and then high for a second window of the same length. This two-phase check keeps noise on the request line from starting a calibration.

While a calibration runs, the controller raises a busy output and drops the enable for the output data clock. The analog calibration itself is outside this block. The calibration engine reports completion with a single-cycle done input. The controller also refuses to start a calibration while dual-edge sampling mode is active. If the request is already high when reset is released, the automatic calibration is skipped. In that case nothing runs until a full low-then-high request sequence has been seen.

Top module: `cal_seq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cal_busy` and `cal_start` are 0 and `dclk_en` is 1.
- R2: An on-command calibration is armed only after `cal_req` has been sampled 0 on QUAL_LEN consecutive rising edges.
- R3: Once armed, sampling `cal_req` as 1 on QUAL_LEN consecutive edges starts a calibration on the edge of the last of those samples. At that edge `cal_busy` rises and `cal_start` is 1 for exactly one cycle. After QUAL_LEN-1 high samples, `cal_busy` is still 0.
- R4: A high sample during the low window restarts that window from zero. A low sample during a partly counted high window cancels the arming, so a full low window is needed again. That low sample counts as the first low of the new window.
- R5: The automatic calibration starts with `cal_busy` visible after edge DLY+1 following reset release. DLY is DLY_LONG when `dly_sel`=1 and DLY_SHORT when `dly_sel`=0. `dly_sel` is sampled only on the first edge after reset release.
- R6: If `cal_req` is 1 on the first edge after reset release, no automatic calibration runs. Only a full low-then-high sequence (R2, R3) starts one.
- R7: `cal_busy` stays 1 until `eng_done` is sampled 1. It is 0 from the following cycle on.
- R8: `dclk_en` is 0 in every cycle where `cal_busy` is 1, and it returns to 1 together with the fall of `cal_busy`.
- R9: While `dual_edge` is 1, no calibration starts. A high window that completes in dual-edge mode is discarded and needs a fresh low window. An expired power-on delay waits until `dual_edge` returns to 0.
- R10: After a calibration ends, holding `cal_req` at 1 never starts another one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_req | input | 1 | Level-sensitive calibration request |
| dly_sel | input | 1 | Power-on delay select: 1 = long, 0 = short |
| dual_edge | input | 1 | Dual-edge sampling mode active |
| eng_done | input | 1 | Single-cycle completion pulse from the calibration engine |
| cal_start | output | 1 | One-cycle pulse telling the engine to begin |
| cal_busy | output | 1 | High while a calibration is in progress |
| dclk_en | output | 1 | Output data clock enable, low during calibration |

## Verification
The request line is swept over low and high run lengths from one short of the qualification window to one past it. This separates an off-by-one in either window from correct behaviour, and also shows whether the cycle of the start is exact. Targeted patterns then check the remaining rules. A single-cycle glitch inside each window shows whether the counter restarts and whether arming is dropped. A held-high request after completion shows that no retrigger occurs. Dual-edge mode is asserted both across a completed request sequence and across the expiry of the power-on delay. Separate resets with each delay select, with the select toggled after sampling, and with the request held high, check the length of the automatic delay and its suppression.

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl #(
  parameter int QUAL_LEN  = 640,
  parameter int DLY_SHORT = 1024,
  parameter int DLY_LONG  = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  input  logic dly_sel,
  input  logic dual_edge,
  input  logic eng_done,
  output logic cal_start,
  output logic cal_busy,
  output logic dclk_en
);

  localparam int MAXC = (DLY_LONG > DLY_SHORT) ?
                        ((DLY_LONG > QUAL_LEN) ? DLY_LONG : QUAL_LEN) :
                        ((DLY_SHORT > QUAL_LEN) ? DLY_SHORT : QUAL_LEN);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] QLIM = CW'(QUAL_LEN - 1);
  localparam logic [CW-1:0] SLIM = CW'(DLY_SHORT - 1);
  localparam logic [CW-1:0] LLIM = CW'(DLY_LONG - 1);

  typedef enum logic [2:0] {S_INIT, S_POR, S_LOW, S_ARM, S_BUSY} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          long_sel;
  logic [CW-1:0] por_lim;

  assign por_lim  = long_sel ? LLIM : SLIM;
  assign cal_busy = (state == S_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_INIT;
      cnt       <= '0;
      long_sel  <= 1'b0;
      cal_start <= 1'b0;
      dclk_en   <= 1'b1;
    end else begin
      cal_start <= 1'b0;
      case (state)
        S_INIT: begin
          long_sel <= dly_sel;
          cnt      <= '0;
          state    <= cal_req ? S_LOW : S_POR;
        end
        S_POR: begin
          if (cnt == por_lim) begin
            if (!dual_edge) begin
              state     <= S_BUSY;
              cal_start <= 1'b1;
              dclk_en   <= 1'b0;
              cnt       <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LOW: begin
          if (cal_req) cnt <= '0;
          else if (cnt == QLIM) begin
            state <= S_ARM;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_ARM: begin
          if (!cal_req) begin
            if (cnt != '0) begin
              state <= S_LOW;
              cnt   <= CW'(1);
            end
          end else if (cnt == QLIM) begin
            cnt <= '0;
            if (dual_edge) state <= S_LOW;
            else begin
              state     <= S_BUSY;
              cal_start <= 1'b1;
              dclk_en   <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_BUSY: begin
          if (eng_done) begin
            state   <= S_LOW;
            cnt     <= '0;
            dclk_en <= 1'b1;
          end
        end
        default: state <= S_INIT;
      endcase
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy && !eng_done |=> cal_busy);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy && eng_done |=> !cal_busy && dclk_en);
  // R8
  dclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !dclk_en);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> cal_busy);
  // R9
  dual_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy && dual_edge |=> !cal_busy);

endmodule

// File: tb/sim_cal_seq_ctrl.sv
module sim_cal_seq_ctrl;
  localparam int Q  = 8;
  localparam int DS = 20;
  localparam int DL = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_req = 1'b0, dly_sel = 1'b0, dual_edge = 1'b0, eng_done = 1'b0;
  logic cal_start, cal_busy, dclk_en;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  cal_seq_ctrl #(.QUAL_LEN(Q), .DLY_SHORT(DS), .DLY_LONG(DL)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .dly_sel(dly_sel),
    .dual_edge(dual_edge), .eng_done(eng_done), .cal_start(cal_start),
    .cal_busy(cal_busy), .dclk_en(dclk_en));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic v, input int n);
    cal_req = v;
    tick(n);
  endtask

  task automatic do_reset(input logic sel, input logic req);
    @(negedge clk);
    rst_n = 1'b0; dly_sel = sel; cal_req = req; dual_edge = 1'b0; eng_done = 1'b0;
    tick(3);
    chk(!cal_busy && !cal_start && dclk_en, "R1", {cal_busy, cal_start, dclk_en}, 1);
    rst_n = 1'b1;
  endtask

  task automatic finish_cal();
    eng_done = 1'b1;
    tick(1);
    eng_done = 1'b0;
    chk(!cal_busy && dclk_en, "R7", {cal_busy, dclk_en}, 1);
  endtask

  task automatic por_len(input logic sel, input int exp);
    int n;
    do_reset(sel, 1'b0);
    n = 0;
    while (!cal_busy && n < DL + 20) begin
      tick(1);
      n++;
      if (n == 1) chk(!cal_busy && dclk_en, "R1", cal_busy, 0);
      if (n == 2) dly_sel = ~sel;
    end
    chk(n == exp, "R5", n, exp);
    chk(cal_start && !dclk_en, "R8", {cal_start, dclk_en}, 2);
    tick(5);
    chk(cal_busy && !dclk_en, "R7", {cal_busy, dclk_en}, 2);
    finish_cal();
  endtask

  initial begin
    por_len(1'b0, DS + 1);
    por_len(1'b1, DL + 1);

    do_reset(1'b0, 1'b0);
    dual_edge = 1'b1;
    tick(DS + 4);
    chk(!cal_busy, "R9", cal_busy, 0);
    dual_edge = 1'b0;
    tick(1);
    chk(cal_busy && cal_start, "R9", {cal_busy, cal_start}, 3);
    finish_cal();

    do_reset(1'b1, 1'b1);
    begin
      int seen = 0;
      for (int i = 0; i < DL + 10; i++) begin
        tick(1);
        if (cal_busy) seen++;
      end
      chk(seen == 0, "R6", seen, 0);
    end

    for (int l = Q - 1; l <= Q + 1; l++) begin
      for (int h = Q - 1; h <= Q + 1; h++) begin
        logic exp;
        drive(1'b0, l);
        chk(!cal_busy, "R2", cal_busy, 0);
        drive(1'b1, h - 1);
        exp = (l >= Q) && (h - 1 >= Q);
        chk(cal_busy == exp, "R3", cal_busy, exp);
        drive(1'b1, 1);
        exp = (l >= Q) && (h >= Q);
        chk(cal_busy == exp, (l < Q) ? "R2" : "R3", cal_busy, exp);
        if (exp && h == Q) begin
          chk(cal_start == 1'b1, "R3", cal_start, 1);
          tick(1);
          chk(cal_start == 1'b0 && cal_busy, "R3", cal_start, 0);
        end
        if (exp) begin
          finish_cal();
          tick(3 * Q);
          chk(!cal_busy, "R10", cal_busy, 0);
        end
      end
    end

    drive(1'b0, Q - 1);
    drive(1'b1, 1);
    drive(1'b0, Q - 1);
    drive(1'b1, Q + 2);
    chk(!cal_busy, "R4", cal_busy, 0);
    drive(1'b0, Q);
    drive(1'b1, Q - 1);
    drive(1'b0, 1);
    drive(1'b1, Q + 2);
    chk(!cal_busy, "R4", cal_busy, 0);
    drive(1'b0, Q);
    drive(1'b1, Q - 1);
    drive(1'b0, 1);
    drive(1'b0, Q - 1);
    drive(1'b1, Q);
    chk(cal_busy && !dclk_en, "R4", {cal_busy, dclk_en}, 2);
    finish_cal();

    drive(1'b0, Q);
    dual_edge = 1'b1;
    drive(1'b1, Q + 3);
    chk(!cal_busy, "R9", cal_busy, 0);
    dual_edge = 1'b0;
    tick(2 * Q);
    chk(!cal_busy, "R9", cal_busy, 0);
    drive(1'b0, Q);
    drive(1'b1, Q);
    chk(cal_busy, "R9", cal_busy, 1);
    finish_cal();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule